// File: doc/BRIEF.md
# Pin Interrupt-on-Change Controller

This block watches a small group of general-purpose input pins and raises an interrupt request when one of them changes in a direction that software has asked to see. Each pin can be armed for rising edges, for falling edges, for both or for neither. Each arm is set through its own bit in one of two enable registers. A qualifying edge latches a per-pin flag. The flag stays latched until software writes a zero to it. A summary flag is formed from all pin flags. The interrupt request is driven when the summary is set and the interrupt enable bit is on.

Pins are asynchronous. Each one passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. Registers sit on a simple bus: a two-bit address, a write strobe, write data, and combinational read data. The map is:

| Address | Register | Bits |
|---|---|---|
| 0 | Control | bit 0 is the read/write interrupt enable; bit 1 is the read-only summary |
| 1 | Pin flags | bits 3..0 |
| 2 | Rising-edge enables | bits 3..0 |
| 3 | Falling-edge enables | bits 3..0 |

Top module: `pin_change_irq`

## Requirements
- R1: When a pin's rising-edge enable bit (address 2, bit i for pin i) is 1 and the pin goes from 0 to 1, its flag (address 1, bit i) reads 1 starting on the third rising clock edge after the pin changes.
- R2: When a pin's falling-edge enable bit (address 3, bit i) is 1 and the pin goes from 1 to 0, its flag reads 1 with the same three-edge latency.
- R3: A pin whose change is not armed for that direction leaves its flag at 0. This covers an enable of 0 and an edge in the opposite direction.
- R4: Flags are sticky. A write to address 1 clears exactly the flag bits written as 0; flag bits written as 1 keep their value.
- R5: If a qualifying edge and a software clear of the same flag reach the same clock edge, the flag ends up set.
- R6: After reset, every register reads 0 and the interrupt output is 0.
- R7: Bits 7..4 of addresses 1, 2 and 3, and bits 7..2 of address 0, always read 0. A write to bit 1 of address 0 has no effect.
- R8: The summary flag (address 0, bit 1) is 1 exactly when at least one pin flag is 1.
- R9: The interrupt output is 1 exactly when the summary flag is 1 and the enable bit (address 0, bit 0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| pins_i | input | 4 | Monitored asynchronous pins |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted flag register shows up at the ports immediately: the flag readback, the summary bit and the interrupt line all depend on it combinationally. The sweep crosses every rising-enable value with every falling-enable value. For each pair it applies several start levels and toggle masks, so any wrong qualifier term is visible in the flags read three edges after the change. A lost event in the set-versus-clear race, or a clear that reaches the wrong bits, is visible on the next read after that write.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int NPINS = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_RISE = 2'd2;
  localparam logic [1:0] A_FALL = 2'd3;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] flags, rise_en, fall_en;
  logic             irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pins_i;
      sync2 <= sync1;
      prev  <= sync2;
    end

  wire [NPINS-1:0] hit = (rise_en & sync2 & ~prev) | (fall_en & ~sync2 & prev);
  wire wr_flag = bus_wr && bus_addr == A_FLAG;
  wire [NPINS-1:0] clr = wr_flag ? ~bus_wdata[NPINS-1:0] : '0;
  wire summary = |flags;
  wire unused_wdata = ^bus_wdata[DW-1:NPINS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      irq_en  <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | hit;
      if (bus_wr && bus_addr == A_RISE) rise_en <= bus_wdata[NPINS-1:0];
      if (bus_wr && bus_addr == A_FALL) fall_en <= bus_wdata[NPINS-1:0];
      if (bus_wr && bus_addr == A_CTRL) irq_en  <= bus_wdata[0];
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0]       = {summary, irq_en};
      A_FLAG:  bus_rdata[NPINS-1:0] = flags;
      A_RISE:  bus_rdata[NPINS-1:0] = rise_en;
      default: bus_rdata[NPINS-1:0] = fall_en;
    endcase
  end

  assign irq_o = summary & irq_en;

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flags & $past(flags)) == $past(flags)));

  // R3
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(hit)) == $past(hit)));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en && flags != '0));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPINS] == '0);

  // R6
  reset_irq_chk: assert property (@(posedge clk) !rst_n |=> !irq_o);
endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] pins = 0;
  logic [1:0] addr = 0;
  logic       wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq;
  int vecs = 0, miss = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_change_irq u_dut (.clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    waitc(3); rst_n = 1;
    for (int a = 0; a < 4; a++) begin rreg(a[1:0], v); chk("R6 reset reg", v, 0); end
    chk("R6 reset irq", {7'd0, irq}, 0);

    // R7: unimplemented bits, read-only summary
    wreg(2, 8'hFF); rreg(2, v); chk("R7 rise upper", v, 8'h0F);
    wreg(3, 8'hF0); rreg(3, v); chk("R7 fall upper", v, 8'h00);
    wreg(0, 8'hFE); rreg(0, v); chk("R7 ctrl summary ro", v, 8'h00);
    wreg(2, 0);

    // Sweep: R1 R2 R3 R8 R9
    for (int re = 0; re < 16; re++)
      for (int fe = 0; fe < 16; fe++)
        for (int k = 0; k < 4; k++) begin
          logic [3:0] p0, p1, m, ex;
          p0 = 4'(re * 5 + fe + k * 7);
          m  = 4'(re ^ (fe << 1) ^ (k * 11) ^ 1);
          p1 = p0 ^ m;
          wreg(2, 0); wreg(3, 0);
          @(negedge clk); pins = p0;
          waitc(4);
          wreg(1, 0);
          wreg(2, 8'(re)); wreg(3, 8'(fe));
          wreg(0, 8'(k & 1));
          @(negedge clk); pins = p1;
          waitc(3);
          ex = (4'(re) & p1 & ~p0) | (4'(fe) & ~p1 & p0);
          rreg(1, v); chk("R1/R2/R3 flags", v, {4'd0, ex});
          rreg(0, v); chk("R8 summary", v, {6'd0, |ex, 1'(k & 1)});
          chk("R9 irq", {7'd0, irq}, {7'd0, (|ex) & 1'(k & 1)});
        end

    // R4: sticky, write-1 ignored, selective clear
    wreg(2, 0); wreg(3, 0);
    @(negedge clk); pins = 0; waitc(4); wreg(1, 0);
    wreg(2, 8'h0F);
    @(negedge clk); pins = 4'hF; waitc(4);
    rreg(1, v); chk("R4 all set", v, 8'h0F);
    wreg(1, 8'hFF); rreg(1, v); chk("R4 write ones ignored", v, 8'h0F);
    waitc(10); rreg(1, v); chk("R4 sticky", v, 8'h0F);
    wreg(1, 8'h0A); rreg(1, v); chk("R4 selective clear", v, 8'h0A);
    wreg(1, 8'h02); rreg(1, v); chk("R4 selective clear 2", v, 8'h02);
    wreg(1, 0);

    // R5: edge and clear on the same clock edge
    wreg(3, 8'h01);
    @(negedge clk); pins = 4'hE;
    @(negedge clk); @(negedge clk);
    addr = 1; wdata = 8'h00; wr = 1;
    @(negedge clk); wr = 0;
    rreg(1, v); chk("R5 set wins", v, 8'h01);

    // R9 gating
    wreg(0, 0); #1 chk("R9 irq off", {7'd0, irq}, 0);
    wreg(0, 1); #1 chk("R9 irq on", {7'd0, irq}, 1);
    wreg(1, 0); #1 chk("R9 irq after clear", {7'd0, irq}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule